// File: doc/BRIEF.md
# I2C Master START Sequencer

This block produces the opening START edge for an I2C master. Software writes a command word whose bit 0 is the start enable. The block then watches the synchronised SDA and SCL lines until the bus is idle. It times one interval from a reload value, pulls SDA low while SCL floats high, and times a second interval. After that it parks with SDA held low and raises a completion flag. Both bus lines are open-drain. Each is driven through an output enable that pulls the line low when set.

The bus is checked before and during the first interval. If both lines are low when the sequence begins, or if either line is seen low before SDA is pulled, a bus collision is flagged. The START is then abandoned and both lines are released. While a START is in flight the block is busy. A write to the transmit buffer is refused and raises a write-collision flag. Command writes are dropped, because commands are not queued.

The buffer and command ports are single-cycle write strobes. They are never back-pressured: a write either lands or is refused, and the flags report which. All four flags are sticky and are cleared by software through a strobe vector.

Top module: `i2c_start_seq`

## Requirements
- R1: When idle, a command write with bit 0 set records the start enable. The block waits, and starts timing only once the synchronised SDA and SCL are both high. If exactly one line is low it keeps waiting, with the start enable still set and neither line pulled.
- R2: With both lines already high, `sda_oe` asserts at the (R+2)th rising edge after the edge that captures the command, where R is `reload_val`. `scl_oe` is never asserted.
- R3: `start_seen` is set on the same edge at which `sda_oe` asserts.
- R4: At the (R+1)th edge after `sda_oe` asserts, `done_irq` is set and command bit 0 is cleared. `sda_oe` then stays asserted until the next accepted command write. A command write with bit 0 clear releases SDA.
- R5: If both lines are sampled low while waiting to begin, `bus_coll` is set, command bit 0 is cleared, and the block returns to idle with both lines released.
- R6: If SCL or SDA is sampled low during the first interval, `bus_coll` is set, the START is abandoned, and neither `start_seen` nor `done_irq` is raised.
- R7: A `tx_wr` while busy sets `wr_coll` and leaves `tx_buf` unchanged. A `tx_wr` when not busy stores `tx_wdata` into `tx_buf`.
- R8: A command write while busy (from the capture edge until `done_irq` or `bus_coll` is set) leaves `cmd_bits` unchanged.
- R9: The flags are sticky. `flag_clr` bit 0 clears `start_seen`, bit 1 clears `done_irq`, bit 2 clears `bus_coll` and bit 3 clears `wr_coll`. A set in the same cycle wins over the clear.
- R10: After reset, all flags, `cmd_bits`, `tx_buf`, `sda_oe` and `scl_oe` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | CMD_W | Command word; bit 0 is start enable |
| cmd_bits | output | CMD_W | Current command register |
| reload_val | input | RELOAD_W | Timer reload value R |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | DATA_W | Transmit buffer write data |
| tx_buf | output | DATA_W | Transmit buffer contents |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| flag_clr | input | 4 | Flag clear strobes |
| start_seen | output | 1 | START edge produced |
| done_irq | output | 1 | START sequence complete |
| bus_coll | output | 1 | Bus collision, START abandoned |
| wr_coll | output | 1 | Buffer write refused while busy |

## Verification
The bench builds the block with RELOAD_W=4, CMD_W=5 and DATA_W=8. This puts both ends of the reload range, 0 and the all-ones value 15, within a few dozen cycles, so the exact edges of both intervals can be checked at each extreme. The narrow reload also leaves the first interval long enough to inject an SCL drop after the synchroniser delay and still land inside it. The five-bit command word carries upper bits whose survival shows that busy-time writes are dropped.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_T1,
    SQ_T2,
    SQ_HOLD
  } seq_state_t;

  localparam int FLAG_N    = 4;
  localparam int FL_START  = 0;
  localparam int FL_DONE   = 1;
  localparam int FL_BCOL   = 2;
  localparam int FL_WCOL   = 3;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    logic stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b1;
        stab <= 1'b1;
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/i2c_interval_timer.sv
module i2c_interval_timer #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (run && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
  import i2c_start_pkg::*;
#(
  parameter int RELOAD_W = 7,
  parameter int CMD_W    = 5,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [CMD_W-1:0]    cmd_wdata,
  output logic [CMD_W-1:0]    cmd_bits,
  input  logic [RELOAD_W-1:0] reload_val,
  input  logic                tx_wr,
  input  logic [DATA_W-1:0]   tx_wdata,
  output logic [DATA_W-1:0]   tx_buf,
  input  logic                sda_in,
  input  logic                scl_in,
  output logic                sda_oe,
  output logic                scl_oe,
  input  logic [3:0]          flag_clr,
  output logic                start_seen,
  output logic                done_irq,
  output logic                bus_coll,
  output logic                wr_coll
);
  seq_state_t st;
  logic [1:0] line_s;
  logic       sda_s, scl_s;
  logic       busy, cmd_take, both_hi, both_lo;
  logic       abort_c, edge_c, done_c;
  logic       tmr_load, tmr_run, tmr_exp;
  logic [CMD_W-1:0]  cmd_q;
  logic [FLAG_N-1:0] flg, flg_set;

  i2c_line_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
  );
  assign sda_s = line_s[0];
  assign scl_s = line_s[1];

  i2c_interval_timer #(.W(RELOAD_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run),
    .load_val(reload_val), .expired(tmr_exp)
  );

  assign busy     = (st == SQ_WAIT) || (st == SQ_T1) || (st == SQ_T2);
  assign cmd_take = cmd_wr && !busy;
  assign both_hi  = sda_s && scl_s;
  assign both_lo  = !sda_s && !scl_s;

  assign abort_c  = ((st == SQ_WAIT) && both_lo) || ((st == SQ_T1) && !both_hi);
  assign edge_c   = (st == SQ_T1) && both_hi && tmr_exp;
  assign done_c   = (st == SQ_T2) && tmr_exp;
  assign tmr_load = ((st == SQ_WAIT) && both_hi) || edge_c;
  assign tmr_run  = (st == SQ_T1) || (st == SQ_T2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else begin
      case (st)
        SQ_IDLE, SQ_HOLD:
          if (cmd_take) st <= cmd_wdata[0] ? SQ_WAIT : SQ_IDLE;
        SQ_WAIT:
          if (both_lo)      st <= SQ_IDLE;
          else if (both_hi) st <= SQ_T1;
        SQ_T1:
          if (!both_hi)     st <= SQ_IDLE;
          else if (tmr_exp) st <= SQ_T2;
        SQ_T2:
          if (tmr_exp)      st <= SQ_HOLD;
        default:            st <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cmd_q <= '0;
    else if (cmd_take)           cmd_q <= cmd_wdata;
    else if (abort_c || done_c)  cmd_q[0] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tx_buf <= '0;
    else if (tx_wr && !busy)   tx_buf <= tx_wdata;
  end

  always_comb begin
    flg_set           = '0;
    flg_set[FL_START] = edge_c;
    flg_set[FL_DONE]  = done_c;
    flg_set[FL_BCOL]  = abort_c;
    flg_set[FL_WCOL]  = tx_wr && busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg <= '0;
    else        flg <= flg_set | (flg & ~flag_clr);
  end

  assign cmd_bits   = cmd_q;
  assign sda_oe     = (st == SQ_T2) || (st == SQ_HOLD);
  assign scl_oe     = 1'b0;
  assign start_seen = flg[FL_START];
  assign done_irq   = flg[FL_DONE];
  assign bus_coll   = flg[FL_BCOL];
  assign wr_coll    = flg[FL_WCOL];

  p_start_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> start_seen);
  p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> (!cmd_q[0] && sda_oe));
  p_abort_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_coll) |-> (!sda_oe && !cmd_q[0]));
  p_wcol_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_wr) |=> (wr_coll && $stable(tx_buf)));
  p_cmd_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q[CMD_W-1:1]));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_wr && flag_clr[3]) |=> wr_coll);
endmodule

// File: tb/i2c_start_seq_bench.sv
module i2c_start_seq_bench;
  localparam int RW = 4;
  localparam int CW = 5;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [CW-1:0] cmd_wdata = '0;
  logic [CW-1:0] cmd_bits;
  logic [RW-1:0] reload_val = '0;
  logic tx_wr = 1'b0;
  logic [DW-1:0] tx_wdata = '0;
  logic [DW-1:0] tx_buf;
  logic sda_in = 1'b1;
  logic scl_in = 1'b1;
  logic sda_oe, scl_oe;
  logic [3:0] flag_clr = '0;
  logic start_seen, done_irq, bus_coll, wr_coll;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int exp_kind[$];
  int exp_cyc[$];
  logic [3:0] prev_f = '0;
  bit ended = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_start_seq #(.RELOAD_W(RW), .CMD_W(CW), .DATA_W(DW)) u_i2c_start_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_bits(cmd_bits), .reload_val(reload_val), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_buf(tx_buf), .sda_in(sda_in), .scl_in(scl_in),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .flag_clr(flag_clr),
    .start_seen(start_seen), .done_irq(done_irq), .bus_coll(bus_coll),
    .wr_coll(wr_coll)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(input int kind, input int at);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
  endtask

  // monitor: each flag rise pops the scoreboard (kind 0 start, 1 done, 2 bcol, 3 wcol)
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] f;
      f = {wr_coll, bus_coll, done_irq, start_seen};
      for (int k = 0; k < 4; k++) begin
        if (f[k] && !prev_f[k]) begin
          if (exp_kind.size() == 0) chk(0, "R6/R9 unexpected flag", k, -1);
          else begin
            int ek, ec;
            ek = exp_kind.pop_front();
            ec = exp_cyc.pop_front();
            chk(ek == k, "R2/R3/R4/R5/R7 event kind", k, ek);
            chk(ec == cyc, "R2/R4 event cycle", cyc, ec);
          end
        end
      end
      prev_f = f;
    end
  end

  task automatic step(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic cmd(input logic [CW-1:0] v, output int at);
    at = cyc;
    cmd_wr = 1'b1;
    cmd_wdata = v;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic clear_all();
    flag_clr = 4'hF;
    @(negedge clk);
    flag_clr = 4'h0;
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_up();
  end

  initial begin
    int n, m;
    step(2);
    rst_n = 1'b1;
    step(3);
    // R10 reset state
    chk(sda_oe == 0, "R10 sda_oe", sda_oe, 0);
    chk(scl_oe == 0, "R10 scl_oe", scl_oe, 0);
    chk({start_seen, done_irq, bus_coll, wr_coll} == 0, "R10 flags",
        {start_seen, done_irq, bus_coll, wr_coll}, 0);
    chk(cmd_bits == 0, "R10 cmd_bits", cmd_bits, 0);
    chk(tx_buf == 0, "R10 tx_buf", tx_buf, 0);

    // R7 idle write lands
    tx_wr = 1; tx_wdata = 8'hA5; step(1); tx_wr = 0;
    chk(tx_buf == 8'hA5, "R7 idle write", tx_buf, 8'hA5);

    // R1/R2/R3/R4 normal START with R=15, plus R7/R8 while busy
    reload_val = 4'd15;
    n = cyc;
    expect_ev(3, n + 4);
    expect_ev(0, n + 18);
    expect_ev(1, n + 34);
    cmd(5'b00001, n);
    step(2);
    tx_wr = 1; tx_wdata = 8'h3C; step(1); tx_wr = 0;
    chk(tx_buf == 8'hA5, "R7 busy write refused", tx_buf, 8'hA5);
    cmd(5'b11110, m);
    chk(cmd_bits == 5'b00001, "R8 busy command dropped", cmd_bits, 1);
    wait_to(n + 17);
    chk(sda_oe == 0, "R2 sda not yet pulled", sda_oe, 0);
    wait_to(n + 18);
    chk(sda_oe == 1, "R2 sda pulled", sda_oe, 1);
    chk(scl_oe == 0, "R2 scl never pulled", scl_oe, 0);
    wait_to(n + 36);
    chk(sda_oe == 1, "R4 sda held after done", sda_oe, 1);
    chk(cmd_bits[0] == 0, "R4 start bit cleared", cmd_bits[0], 0);

    // R9 clear strobes
    clear_all();
    chk({start_seen, done_irq, bus_coll, wr_coll} == 0, "R9 clear",
        {start_seen, done_irq, bus_coll, wr_coll}, 0);
    cmd(5'b00000, m);
    chk(sda_oe == 0, "R4 release on command", sda_oe, 1'b0);
    step(3);

    // R=0 edge, with R9 set-over-clear on wr_coll
    reload_val = 4'd0;
    n = cyc;
    expect_ev(3, n + 2);
    expect_ev(0, n + 3);
    expect_ev(1, n + 4);
    cmd(5'b00001, n);
    tx_wr = 1; flag_clr = 4'b1000; step(1); tx_wr = 0; flag_clr = 0;
    chk(wr_coll == 1, "R9 set wins over clear", wr_coll, 1);
    wait_to(n + 6);
    chk(sda_oe == 1 && cmd_bits[0] == 0, "R4 R=0 completion", sda_oe, 1);
    clear_all();
    cmd(5'b00000, m);
    step(3);

    // R1 wait while only SDA low, then proceed (R=3)
    reload_val = 4'd3;
    sda_in = 0; step(3);
    cmd(5'b00001, n);
    step(6);
    chk(cmd_bits[0] == 1, "R1 start held while waiting", cmd_bits[0], 1);
    chk(sda_oe == 0, "R1 no pull while waiting", sda_oe, 0);
    m = cyc;
    expect_ev(0, m + 7);
    expect_ev(1, m + 11);
    sda_in = 1;
    wait_to(m + 13);
    clear_all();
    cmd(5'b00000, m);
    step(3);

    // R5 both low at begin
    sda_in = 0; scl_in = 0; step(3);
    n = cyc;
    expect_ev(2, n + 2);
    cmd(5'b00001, n);
    wait_to(n + 3);
    chk(cmd_bits[0] == 0, "R5 start bit dropped", cmd_bits[0], 0);
    chk(sda_oe == 0, "R5 lines released", sda_oe, 0);
    sda_in = 1; scl_in = 1; step(3);
    clear_all();

    // R6 SCL drops inside first interval (R=15)
    reload_val = 4'd15;
    n = cyc;
    expect_ev(2, n + 6);
    cmd(5'b00001, n);
    wait_to(n + 3);
    scl_in = 0;
    wait_to(n + 7);
    scl_in = 1;
    chk(sda_oe == 0, "R6 sda released after abort", sda_oe, 0);
    chk(cmd_bits[0] == 0, "R6 start bit dropped", cmd_bits[0], 0);
    wait_to(n + 40);
    chk(start_seen == 0 && done_irq == 0, "R6 no start/done",
        {start_seen, done_irq}, 0);
    chk(exp_kind.size() == 0, "R2 scoreboard drained", exp_kind.size(), 0);
    finish_up();
  end
endmodule